// File: doc/BRIEF.md
# Coprocessor Instruction Stream Tracker

This block sits beside a host processor and watches it without ever driving the bus. The host prefetches instruction bytes into a small queue and reports, on two queue status lines, when it takes a byte from that queue. The tracker keeps its own copy of the queue. It fills the copy from the fetch cycles it sees and drains it as the status lines report. As a result it always knows which byte the host has just begun to execute.

When the host starts an instruction whose first byte carries the escape tag, the tracker keeps the low three bits of that byte. When the next byte of the same instruction is taken, it joins those bits to three bits of that byte to form a six-bit coprocessor opcode. It also splits out the two-bit addressing mode and the three-bit register/memory field. It then pulses a valid strobe and reports whether a memory operand cycle will follow. A downstream execution unit uses these outputs to start work and to decide whether to capture an operand from the bus.

Two host variants are supported, one with a 16-bit data bus and one with an 8-bit data bus. The tracker learns which one it serves from a single bus line that it samples just after reset. It then sets the depth and fill width of its queue copy to match.

Top module: `cop_stream_tracker`

## Requirements
- R1: While reset is asserted and right after it is released, `cop_valid`, `cop_memop`, `cop_opcode`, `cop_mode` and `cop_rm` are all zero and the queue copy is empty.
- R2: On the first rising clock edge after reset is released, the tracker samples `bus_data[7]`. A 1 selects the 8-bit host and a 0 selects the 16-bit host. The strobe and status inputs of that cycle are ignored, and the choice holds until the next reset.
- R3: A fetch strobe appends bytes to the queue copy. On the 16-bit host it appends `bus_data[7:0]` and then `bus_data[15:8]`. On the 8-bit host it appends only `bus_data[7:0]`. The depth is 6 bytes for the 16-bit host and 4 bytes for the 8-bit host, and a fetch that would exceed the depth is dropped whole.
- R4: The status code is `qstat` = 00 for idle (no change), 01 for taking the first byte of an instruction, 10 for a flush, and 11 for taking a later byte. Each take removes the oldest byte.
- R5: A first-byte take whose byte has bits [7:3] = 11011 arms the decoder. Any other first-byte take, including one on an empty queue, disarms it.
- R6: A later-byte take while armed drives `cop_opcode` = {escape byte[2:0], byte[5:3]}, `cop_mode` = byte[7:6] and `cop_rm` = byte[2:0]. It raises `cop_valid` for exactly the one cycle after that take, and then disarms.
- R7: With each decode, `cop_memop` is 1 when `cop_mode` is not 11 and 0 when it is 11.
- R8: A flush empties the queue copy and disarms the decoder. A fetch in the same cycle is discarded.
- R9: Takes on an empty queue, later-byte takes while not armed, and idle cycles give no valid strobe, and the decoded fields hold their last values.
- R10: When a take and a fetch occur in the same cycle, the take removes the oldest byte held before that cycle and the fetched bytes join behind the remaining ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | 16 | Host data bus as seen during fetches, and the sense line after reset |
| fetch_stb | input | 1 | High for one cycle when the host fetches code from the bus |
| qstat | input | 2 | Host queue status code |
| cop_opcode | output | 6 | Decoded coprocessor opcode |
| cop_mode | output | 2 | Addressing mode field |
| cop_rm | output | 3 | Register/memory field |
| cop_valid | output | 1 | One-cycle strobe marking a new decode |
| cop_memop | output | 1 | A memory operand cycle follows this instruction |

## Verification
The checker assumes that `qstat`, `fetch_stb` and `bus_data` carry defined values on every edge once the host type has been sensed. It also assumes that `bus_data[7]` is settled at the first edge after reset. The stimulus sets every input to a defined value during reset and changes inputs only on falling edges. It deliberately breaks the host's own rules, with takes from an empty queue and fetches into a full one, because the checker's properties do not rely on a well-behaved host.

// File: rtl/cst_pkg.sv
package cst_pkg;

  // host queue status codes
  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_FLUSH = 2'b10,
    QS_NEXT  = 2'b11
  } qstat_e;

  // leading five bits that mark a coprocessor instruction
  localparam logic [4:0] ESC_TAG = 5'b11011;

  typedef struct packed {
    logic [5:0] opcode;
    logic [1:0] mode;
    logic [2:0] rm;
  } dec_t;

endpackage

// File: rtl/cst_queue.sv
module cst_queue #(
  parameter int BUS_W        = 16,
  parameter int WIDE_DEPTH   = 6,
  parameter int NARROW_DEPTH = 4,
  localparam int CW          = $clog2(WIDE_DEPTH + 1),
  localparam int LANES       = BUS_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             narrow_i,
  input  logic             fetch_i,
  input  logic [BUS_W-1:0] bus_i,
  input  logic             take_i,
  input  logic             flush_i,
  output logic [7:0]       head_o,
  output logic             head_vld_o,
  output logic [CW-1:0]    cnt_o
);

  localparam logic [CW-1:0] WLIM = CW'(WIDE_DEPTH);
  localparam logic [CW-1:0] NLIM = CW'(NARROW_DEPTH);
  localparam logic [CW-1:0] WSTEP = CW'(LANES);

  logic [7:0]    mem_q [WIDE_DEPTH];
  logic [7:0]    mem_n [WIDE_DEPTH];
  logic [CW-1:0] cnt_q, cnt_n;

  // next state: pop first (old head), then append behind survivors
  always_comb begin
    for (int i = 0; i < WIDE_DEPTH; i++) mem_n[i] = mem_q[i];
    cnt_n = cnt_q;
    if (en_i) begin
      if (flush_i) begin
        cnt_n = '0;
      end else begin
        if (take_i && (cnt_q != '0)) begin
          for (int i = 0; i < WIDE_DEPTH - 1; i++) mem_n[i] = mem_q[i+1];
          cnt_n = cnt_q - CW'(1);
        end
        if (fetch_i) begin
          if (narrow_i) begin
            if (cnt_n < NLIM) begin
              mem_n[cnt_n] = bus_i[7:0];
              cnt_n        = cnt_n + CW'(1);
            end
          end else if (cnt_n <= (WLIM - WSTEP)) begin
            for (int l = 0; l < LANES; l++) mem_n[cnt_n + CW'(l)] = bus_i[8*l +: 8];
            cnt_n = cnt_n + WSTEP;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < WIDE_DEPTH; i++) mem_q[i] <= '0;
    end else if (en_i) begin
      cnt_q <= cnt_n;
      for (int i = 0; i < WIDE_DEPTH; i++) mem_q[i] <= mem_n[i];
    end
  end

  assign head_o     = mem_q[0];
  assign head_vld_o = (cnt_q != '0);
  assign cnt_o      = cnt_q;

endmodule

// File: rtl/cst_decode.sv
module cst_decode
  import cst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  qstat_e     qs_i,
  input  logic [7:0] head_i,
  input  logic       head_vld_i,
  output dec_t       dec_o,
  output logic       valid_o,
  output logic       memop_o
);

  logic       armed_q, armed_n;
  logic [2:0] esc_q, esc_n;
  dec_t       dec_q, dec_n;
  logic       valid_q, valid_n;
  logic       memop_q, memop_n;

  always_comb begin
    armed_n = armed_q;
    esc_n   = esc_q;
    dec_n   = dec_q;
    valid_n = 1'b0;
    memop_n = memop_q;
    if (en_i) begin
      unique case (qs_i)
        QS_FLUSH: armed_n = 1'b0;
        QS_FIRST: begin
          armed_n = head_vld_i && (head_i[7:3] == ESC_TAG);
          esc_n   = head_i[2:0];
        end
        QS_NEXT: begin
          if (head_vld_i && armed_q) begin
            dec_n.opcode = {esc_q, head_i[5:3]};
            dec_n.mode   = head_i[7:6];
            dec_n.rm     = head_i[2:0];
            memop_n      = (head_i[7:6] != 2'b11);
            valid_n      = 1'b1;
            armed_n      = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      esc_q   <= '0;
      dec_q   <= '0;
      valid_q <= 1'b0;
      memop_q <= 1'b0;
    end else begin
      armed_q <= armed_n;
      esc_q   <= esc_n;
      dec_q   <= dec_n;
      valid_q <= valid_n;
      memop_q <= memop_n;
    end
  end

  assign dec_o   = dec_q;
  assign valid_o = valid_q;
  assign memop_o = memop_q;

endmodule

// File: rtl/cop_stream_tracker.sv
module cop_stream_tracker
  import cst_pkg::*;
#(
  parameter int BUS_W        = 16,
  parameter int WIDE_DEPTH   = 6,
  parameter int NARROW_DEPTH = 4,
  parameter int SENSE_BIT    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] bus_data,
  input  logic             fetch_stb,
  input  logic [1:0]       qstat,
  output logic [5:0]       cop_opcode,
  output logic [1:0]       cop_mode,
  output logic [2:0]       cop_rm,
  output logic             cop_valid,
  output logic             cop_memop
);

  localparam int CW = $clog2(WIDE_DEPTH + 1);

  // host type sensing
  logic sensed_q, sensed_n;
  logic narrow_q, narrow_n;

  always_comb begin
    sensed_n = sensed_q;
    narrow_n = narrow_q;
    if (!sensed_q) begin
      sensed_n = 1'b1;
      narrow_n = bus_data[SENSE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sensed_q <= 1'b0;
      narrow_q <= 1'b0;
    end else begin
      sensed_q <= sensed_n;
      narrow_q <= narrow_n;
    end
  end

  qstat_e        qs;
  logic          take, flush;
  logic [7:0]    head;
  logic          head_vld;
  logic [CW-1:0] q_cnt;
  dec_t          dec;

  assign qs    = qstat_e'(qstat);
  assign take  = (qs == QS_FIRST) || (qs == QS_NEXT);
  assign flush = (qs == QS_FLUSH);

  cst_queue #(
    .BUS_W       (BUS_W),
    .WIDE_DEPTH  (WIDE_DEPTH),
    .NARROW_DEPTH(NARROW_DEPTH)
  ) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (sensed_q),
    .narrow_i  (narrow_q),
    .fetch_i   (fetch_stb),
    .bus_i     (bus_data),
    .take_i    (take),
    .flush_i   (flush),
    .head_o    (head),
    .head_vld_o(head_vld),
    .cnt_o     (q_cnt)
  );

  cst_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (sensed_q),
    .qs_i      (qs),
    .head_i    (head),
    .head_vld_i(head_vld),
    .dec_o     (dec),
    .valid_o   (cop_valid),
    .memop_o   (cop_memop)
  );

  assign cop_opcode = dec.opcode;
  assign cop_mode   = dec.mode;
  assign cop_rm     = dec.rm;

endmodule

// File: rtl/cst_checker.sv
module cst_checker #(
  parameter int WIDE_DEPTH   = 6,
  parameter int NARROW_DEPTH = 4,
  parameter int CW           = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    qstat,
  input logic          cop_valid,
  input logic [1:0]    cop_mode,
  input logic          cop_memop,
  input logic          sensed_q,
  input logic          narrow_q,
  input logic [CW-1:0] q_cnt
);

  // R2
  sense_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sensed_q |=> !cop_valid);

  // R2
  host_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sensed_q |=> $stable(narrow_q));

  // R3
  depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= (narrow_q ? CW'(NARROW_DEPTH) : CW'(WIDE_DEPTH)));

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_valid |=> !cop_valid);

  // R6
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sensed_q && (qstat != 2'b11) |=> !cop_valid);

  // R7
  regform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_valid && (cop_mode == 2'b11) |-> !cop_memop);

  // R7
  memform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cop_valid && (cop_mode != 2'b11) |-> cop_memop);

  // R8
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sensed_q && (qstat == 2'b10) |=> !cop_valid && (q_cnt == '0));

endmodule

bind cop_stream_tracker cst_checker #(
  .WIDE_DEPTH  (WIDE_DEPTH),
  .NARROW_DEPTH(NARROW_DEPTH),
  .CW          (CW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .qstat    (qstat),
  .cop_valid(cop_valid),
  .cop_mode (cop_mode),
  .cop_memop(cop_memop),
  .sensed_q (sensed_q),
  .narrow_q (narrow_q),
  .q_cnt    (q_cnt)
);

// File: tb/sim_cop_stream_tracker.sv
module sim_cop_stream_tracker;

  logic        clk;
  logic        rst_n;
  logic [15:0] bus;
  logic        fetch;
  logic [1:0]  qs;
  logic [5:0]  o_op;
  logic [1:0]  o_mode;
  logic [2:0]  o_rm;
  logic        o_valid;
  logic        o_mem;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  cop_stream_tracker u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_data  (bus),
    .fetch_stb (fetch),
    .qstat     (qs),
    .cop_opcode(o_op),
    .cop_mode  (o_mode),
    .cop_rm    (o_rm),
    .cop_valid (o_valid),
    .cop_memop (o_mem)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // behavioural reference model
  logic [7:0] mq[$];
  bit         m_sensed, m_narrow, m_armed;
  logic [2:0] m_esc;
  logic [5:0] m_op;
  logic [1:0] m_mode;
  logic [2:0] m_rm;
  logic       m_valid, m_mem;
  logic [7:0] mb;
  int         lim;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mq.delete();
      m_sensed = 0; m_narrow = 0; m_armed = 0; m_esc = 0;
      m_op = 0; m_mode = 0; m_rm = 0; m_valid = 0; m_mem = 0;
    end else if (!m_sensed) begin
      m_sensed = 1;
      m_narrow = bus[7];
      m_valid  = 0;
    end else begin
      m_valid = 0;
      lim = m_narrow ? 4 : 6;
      if (qs == 2'b10) begin
        mq.delete();
        m_armed = 0;
      end else begin
        if (qs == 2'b01 || qs == 2'b11) begin
          if (mq.size() > 0) begin
            mb = mq.pop_front();
            if (qs == 2'b01) begin
              m_armed = (mb[7:3] == 5'b11011);
              m_esc   = mb[2:0];
            end else if (m_armed) begin
              m_op    = {m_esc, mb[5:3]};
              m_mode  = mb[7:6];
              m_rm    = mb[2:0];
              m_mem   = (mb[7:6] != 2'b11);
              m_valid = 1;
              m_armed = 0;
            end
          end else if (qs == 2'b01) begin
            m_armed = 0;
          end
        end
        if (fetch) begin
          if (m_narrow) begin
            if (mq.size() < lim) mq.push_back(bus[7:0]);
          end else if (mq.size() + 2 <= lim) begin
            mq.push_back(bus[7:0]);
            mq.push_back(bus[15:8]);
          end
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk("R6 model valid", 32'(o_valid), 32'(m_valid));
    chk("R6 model fields", {21'd0, o_op, o_mode, o_rm}, {21'd0, m_op, m_mode, m_rm});
    chk("R7 model memop", 32'(o_mem), 32'(m_mem));
  endtask

  // drive one cycle from a falling edge, compare just after the rising edge
  task automatic step(input logic f, input logic [15:0] d, input logic [1:0] q);
    fetch = f; bus = d; qs = q;
    @(posedge clk);
    #1;
    cmp_model();
    @(negedge clk);
  endtask

  task automatic exp_dec(input string req, input logic [5:0] op, input logic [1:0] md,
                         input logic [2:0] rm, input logic mem);
    chk(req, {20'd0, o_valid, o_op, o_mode, o_rm, o_mem},
             {20'd0, 1'b1, op, md, rm, mem});
  endtask

  task automatic exp_none(input string req);
    chk(req, 32'(o_valid), 32'd0);
  endtask

  task automatic do_reset(input logic sense);
    @(negedge clk);
    rst_n = 1'b0; fetch = 1'b0; qs = 2'b00; bus = '0;
    repeat (2) @(negedge clk);
    chk("R1 reset outputs", {21'd0, o_valid, o_mem, o_op, o_mode, o_rm}, 32'd0);
    rst_n = 1'b1;
    // sense cycle: activity must be ignored
    step(1'b1, sense ? 16'h00DE : 16'h0041, 2'b01);
    exp_none("R1 after release");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected<=20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fetch = 1'b0; qs = 2'b00; bus = '0;

    // ---------------- 16-bit host ----------------
    do_reset(1'b0);

    // R5 R6 R7 R4: register form with an idle gap between the two takes
    step(1'b1, 16'hC1D9, 2'b00);
    step(1'b0, 16'h0000, 2'b01);
    step(1'b0, 16'h0000, 2'b00);
    exp_none("R4 idle no strobe");
    step(1'b0, 16'h0000, 2'b11);
    exp_dec("R6 register form", 6'b001000, 2'b11, 3'd1, 1'b0);
    step(1'b0, 16'h0000, 2'b00);
    exp_none("R6 one-cycle strobe");
    chk("R9 fields hold", {26'd0, o_op}, {26'd0, 6'b001000});

    // R7 memory form
    step(1'b1, 16'h46DE, 2'b00);
    step(1'b0, 16'h0000, 2'b01);
    step(1'b0, 16'h0000, 2'b11);
    exp_dec("R7 memory form", 6'b110000, 2'b01, 3'd6, 1'b1);

    // R9 non-escape first byte
    step(1'b1, 16'hC18B, 2'b00);
    step(1'b0, 16'h0000, 2'b01);
    step(1'b0, 16'h0000, 2'b11);
    exp_none("R9 non-escape");

    // R8 flush disarms
    step(1'b1, 16'h05D8, 2'b00);
    step(1'b0, 16'h0000, 2'b01);
    step(1'b0, 16'h0000, 2'b10);
    step(1'b1, 16'hC3C3, 2'b00);
    step(1'b0, 16'h0000, 2'b11);
    exp_none("R8 flush disarms");
    step(1'b0, 16'h0000, 2'b11);

    // R8 fetch alongside flush is discarded
    step(1'b1, 16'hC0D8, 2'b10);
    step(1'b0, 16'h0000, 2'b01);
    step(1'b0, 16'h0000, 2'b11);
    exp_none("R8 fetch during flush");

    // R9 takes on empty queue
    step(1'b0, 16'h0000, 2'b11);
    exp_none("R9 empty later take");
    step(1'b0, 16'h0000, 2'b01);
    step(1'b0, 16'h0000, 2'b11);
    exp_none("R9 empty first take");

    // R3 wide depth: fourth word dropped
    step(1'b1, 16'hC1D9, 2'b00);
    step(1'b1, 16'hC2DA, 2'b00);
    step(1'b1, 16'hC3DB, 2'b00);
    step(1'b1, 16'hC4DC, 2'b00);
    step(1'b0, 16'h0000, 2'b01);
    step(1'b0, 16'h0000, 2'b11);
    exp_dec("R3 wide byte order 1", 6'b001000, 2'b11, 3'd1, 1'b0);
    step(1'b0, 16'h0000, 2'b01);
    step(1'b0, 16'h0000, 2'b11);
    exp_dec("R3 wide byte order 2", 6'b010000, 2'b11, 3'd2, 1'b0);
    step(1'b0, 16'h0000, 2'b01);
    step(1'b0, 16'h0000, 2'b11);
    exp_dec("R3 wide byte order 3", 6'b011000, 2'b11, 3'd3, 1'b0);
    step(1'b0, 16'h0000, 2'b01);
    step(1'b0, 16'h0000, 2'b11);
    exp_none("R3 wide overflow dropped");

    // R10 take and fetch together
    step(1'b1, 16'hC7DD, 2'b00);
    step(1'b1, 16'h1EDF, 2'b01);
    step(1'b0, 16'h0000, 2'b11);
    exp_dec("R10 old head taken", 6'b101000, 2'b11, 3'd7, 1'b0);
    step(1'b0, 16'h0000, 2'b01);
    step(1'b0, 16'h0000, 2'b11);
    exp_dec("R10 fetched bytes behind", 6'b111011, 2'b00, 3'd6, 1'b1);

    // ---------------- 8-bit host ----------------
    do_reset(1'b1);
    step(1'b1, 16'hFFD9, 2'b00);
    step(1'b1, 16'hAAC1, 2'b00);
    step(1'b1, 16'h00DA, 2'b00);
    step(1'b1, 16'h00C2, 2'b00);
    step(1'b1, 16'h00DB, 2'b00);
    step(1'b0, 16'h0000, 2'b01);
    step(1'b0, 16'h0000, 2'b11);
    exp_dec("R2 narrow low byte only", 6'b001000, 2'b11, 3'd1, 1'b0);
    step(1'b0, 16'h0000, 2'b01);
    step(1'b0, 16'h0000, 2'b11);
    exp_dec("R2 narrow second", 6'b010000, 2'b11, 3'd2, 1'b0);
    step(1'b1, 16'h00C3, 2'b00);
    step(1'b0, 16'h0000, 2'b01);
    step(1'b0, 16'h0000, 2'b11);
    exp_none("R3 narrow overflow dropped");

    repeat (3) step(1'b0, 16'h0000, 2'b00);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule